// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host on a 32-bit memory-mapped bus reach a second, internal register bus that the host cannot address directly. The host sees a small window of four word registers: command, target address, returned read data and outgoing write data. A host write to the command register starts exactly one transfer on the internal bus. When the transfer finishes, the block sets an acknowledge bit. That bit stays set until the host writes zero to the command register.

For a write, the host first loads the outgoing data, then the target address, then the write command. For a read, the host loads the address, issues the read command, waits for acknowledge and then fetches the result from the read-data register. Every transfer ends with the host writing zero to the command register. The block then returns to a fully cleared command value and can accept the next command.

The internal side is a simple master. It holds a request strobe together with address, write data and a write-enable until the target answers with a ready pulse that also carries read data. The host side answers every read one cycle later, flagged by a valid strobe.

Top module: `ind_bridge`

## Requirements
- R1: After a synchronous active-high reset, all four window registers read back as zero and the internal request is low.
- R2: Host reads return the current register value one cycle after the read strobe, with `host_rvalid` high in that cycle. The window starts at byte offset 0x400. Command is at +0x0, address at +0x4, read data at +0x8 and write data at +0xC. Any other word inside the 32-byte window, and any address outside it, reads as zero.
- R3: When idle, a host write to the command register whose low two bits are 2'b10 starts an internal write. From the next cycle `ib_req` and `ib_we` are high, and `ib_addr` and `ib_wdata` carry the values loaded earlier.
- R4: When idle, a command with low bits 2'b01 starts an internal read (`ib_we` low). The `ib_rdata` value present with `ib_ready` is stored in the read-data register.
- R5: `ib_req` stays high until a cycle in which `ib_ready` is high. In the next cycle the request is low and the command register reads as the request bit plus the acknowledge bit (bit 2): 0x5 for a read, 0x6 for a write.
- R6: Acknowledge stays set until the host writes a full-zero word to the command register. After that the command register reads zero and a new command is accepted.
- R7: A command whose low two bits are 2'b11 is ignored. No request is made, no acknowledge appears and the command register still reads zero.
- R8: Host writes to the address or write-data register while a transfer is in flight are dropped. The internal bus and the later read-back keep the earlier values.
- R9: Command writes other than zero while a transfer is in flight or acknowledged are ignored. The command value is unchanged.
- R10: The command register never changes without a host command write or a transfer completion. A `ib_ready` pulse with no request pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | HADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, one cycle after `host_rd` |
| host_rvalid | output | 1 | High in the cycle `host_rdata` is valid |
| ib_req | output | 1 | Internal bus request, held until ready |
| ib_we | output | 1 | Internal bus write-enable |
| ib_addr | output | IADDR_W | Internal bus address |
| ib_wdata | output | DATA_W | Internal bus write data |
| ib_ready | input | 1 | Internal bus completion strobe |
| ib_rdata | input | DATA_W | Internal bus read data, valid with `ib_ready` |

## Verification
The assertions assume that the host never asserts read and write strobes in the same cycle, and that `ib_ready` is a single-cycle answer to a pending request. A stray ready with no request is the one exception they tolerate. The stimulus issues one host access at a time and drives `ib_ready` from a responder that watches `ib_req` and counts a chosen latency. A stray ready is raised only while the bridge is idle, which is how the no-effect case is exercised.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_BUSY = 2'd1,
    XS_DONE = 2'd2
  } xfer_state_e;

  // word slots inside the window
  localparam int unsigned SLOT_CMD  = 0;
  localparam int unsigned SLOT_ADDR = 1;
  localparam int unsigned SLOT_RDAT = 2;
  localparam int unsigned SLOT_WDAT = 3;
  localparam int unsigned NUM_REGS  = 4;

  // command word bit positions
  localparam int unsigned BIT_RD  = 0;
  localparam int unsigned BIT_WR  = 1;
  localparam int unsigned BIT_ACK = 2;
  localparam int unsigned CMD_W   = 3;
endpackage

// File: rtl/ind_bridge_dec.sv
module ind_bridge_dec
  import ind_bridge_pkg::*;
#(
  parameter int unsigned HADDR_W   = 12,
  parameter int unsigned WIN_BASE  = 'h400,
  parameter int unsigned WIN_BYTES = 32
) (
  input  logic [HADDR_W-1:0]  host_addr,
  output logic [NUM_REGS-1:0] sel
);
  localparam int unsigned SLOT_W = $clog2(WIN_BYTES / 4);
  localparam int unsigned LOW_W  = SLOT_W + 2;
  localparam logic [HADDR_W-1:0] BASE_V = HADDR_W'(WIN_BASE);

  logic              in_win;
  logic [SLOT_W-1:0] slot;

  assign in_win = (host_addr[HADDR_W-1:LOW_W] == BASE_V[HADDR_W-1:LOW_W]) &&
                  (host_addr[1:0] == 2'b00);
  assign slot   = host_addr[LOW_W-1:2];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel[g] = in_win && (slot == SLOT_W'(g));
  end
endmodule

// File: rtl/ind_bridge_fsm.sv
module ind_bridge_fsm
  import ind_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic             ib_ready,
  output logic             ib_req,
  output logic             ib_we,
  output logic             done,
  output logic [CMD_W-1:0] cmd_view
);
  xfer_state_e state_q;
  logic        rd_f_q;
  logic        wr_f_q;
  logic        start_ok;
  logic        clear_ok;

  assign start_ok = cmd_wr && (cmd_data[1:0] == 2'b01 || cmd_data[1:0] == 2'b10);
  assign clear_ok = cmd_wr && (cmd_data == '0);
  assign done     = (state_q == XS_BUSY) && ib_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      rd_f_q  <= 1'b0;
      wr_f_q  <= 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: begin
          if (start_ok) begin
            rd_f_q  <= cmd_data[BIT_RD];
            wr_f_q  <= cmd_data[BIT_WR];
            state_q <= XS_BUSY;
          end
        end
        XS_BUSY: begin
          if (ib_ready) state_q <= XS_DONE;
        end
        XS_DONE: begin
          if (clear_ok) begin
            rd_f_q  <= 1'b0;
            wr_f_q  <= 1'b0;
            state_q <= XS_IDLE;
          end
        end
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign ib_req = (state_q == XS_BUSY);
  assign ib_we  = wr_f_q;

  always_comb begin
    cmd_view          = '0;
    cmd_view[BIT_RD]  = rd_f_q;
    cmd_view[BIT_WR]  = wr_f_q;
    cmd_view[BIT_ACK] = (state_q == XS_DONE);
  end
endmodule

// File: rtl/ind_bridge.sv
module ind_bridge
  import ind_bridge_pkg::*;
#(
  parameter int unsigned HADDR_W   = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned IADDR_W   = 24,
  parameter int unsigned WIN_BASE  = 'h400,
  parameter int unsigned WIN_BYTES = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               ib_req,
  output logic               ib_we,
  output logic [IADDR_W-1:0] ib_addr,
  output logic [DATA_W-1:0]  ib_wdata,
  input  logic               ib_ready,
  input  logic [DATA_W-1:0]  ib_rdata
);
  logic [NUM_REGS-1:0] sel;
  logic [CMD_W-1:0]    cmd_view;
  logic                done;
  logic [IADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]   wdat_q;
  logic [DATA_W-1:0]   rdat_q;
  logic [DATA_W-1:0]   rd_mux;

  ind_bridge_dec #(
    .HADDR_W  (HADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_BYTES(WIN_BYTES)
  ) u_dec (
    .host_addr(host_addr),
    .sel      (sel)
  );

  ind_bridge_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (host_wr && sel[SLOT_CMD]),
    .cmd_data(host_wdata),
    .ib_ready(ib_ready),
    .ib_req  (ib_req),
    .ib_we   (ib_we),
    .done    (done),
    .cmd_view(cmd_view)
  );

  // operand registers, frozen while a transfer is in flight
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (host_wr && !ib_req) begin
      if (sel[SLOT_ADDR]) addr_q <= host_wdata[IADDR_W-1:0];
      if (sel[SLOT_WDAT]) wdat_q <= host_wdata;
    end
  end

  // returned data captured on read completion
  always_ff @(posedge clk) begin
    if (rst) begin
      rdat_q <= '0;
    end else if (done && !ib_we) begin
      rdat_q <= ib_rdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (sel[SLOT_CMD])  rd_mux = DATA_W'(cmd_view);
    if (sel[SLOT_ADDR]) rd_mux = DATA_W'(addr_q);
    if (sel[SLOT_RDAT]) rd_mux = rdat_q;
    if (sel[SLOT_WDAT]) rd_mux = wdat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_mux;
    end
  end

  assign ib_addr  = addr_q;
  assign ib_wdata = wdat_q;
endmodule

// File: rtl/ind_bridge_chk.sv
module ind_bridge_chk #(
  parameter int unsigned HADDR_W  = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IADDR_W  = 24,
  parameter int unsigned WIN_BASE = 'h400
) (
  input logic               clk,
  input logic               rst,
  input logic               host_wr,
  input logic               host_rd,
  input logic [HADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0]  host_wdata,
  input logic               host_rvalid,
  input logic               ib_req,
  input logic               ib_ready,
  input logic [IADDR_W-1:0] ib_addr,
  input logic [DATA_W-1:0]  ib_wdata,
  input logic [2:0]         cmd_view
);
  logic cmd_hit;
  assign cmd_hit = host_wr && (host_addr == HADDR_W'(WIN_BASE));

  a_r2_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  a_r2_rvalid_quiet: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> !host_rvalid);
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    ib_req && !ib_ready |=> ib_req);
  a_r5_ack_on_done: assert property (@(posedge clk) disable iff (rst)
    ib_req && ib_ready |=> !ib_req && cmd_view[2]);
  a_r8_operands_stable: assert property (@(posedge clk) disable iff (rst)
    ib_req |=> $stable(ib_addr) && $stable(ib_wdata));
  a_r6_ack_held: assert property (@(posedge clk) disable iff (rst)
    cmd_view[2] && !(cmd_hit && host_wdata == '0) |=> cmd_view[2]);
  a_r6_ack_cleared: assert property (@(posedge clk) disable iff (rst)
    cmd_view[2] && cmd_hit && host_wdata == '0 |=> cmd_view == 3'b000);
  a_r7_both_ignored: assert property (@(posedge clk) disable iff (rst)
    cmd_view == 3'b000 && cmd_hit && host_wdata[1:0] == 2'b11 |=> !ib_req && cmd_view == 3'b000);
  a_r10_no_spontaneous: assert property (@(posedge clk) disable iff (rst)
    cmd_view == 3'b000 && !cmd_hit |=> cmd_view == 3'b000);
endmodule

bind ind_bridge ind_bridge_chk #(
  .HADDR_W (HADDR_W),
  .DATA_W  (DATA_W),
  .IADDR_W (IADDR_W),
  .WIN_BASE(WIN_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rvalid(host_rvalid),
  .ib_req     (ib_req),
  .ib_ready   (ib_ready),
  .ib_addr    (ib_addr),
  .ib_wdata   (ib_wdata),
  .cmd_view   (cmd_view)
);

// File: tb/ind_bridge_bench.sv
module ind_bridge_bench;
  localparam int HW = 12;
  localparam int DW = 32;
  localparam int AW = 24;
  localparam logic [31:0] AMASK = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_wr = 1'b0;
  logic          host_rd = 1'b0;
  logic [HW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          host_rvalid;
  logic          ib_req;
  logic          ib_we;
  logic [AW-1:0] ib_addr;
  logic [DW-1:0] ib_wdata;
  logic          ib_ready = 1'b0;
  logic [DW-1:0] ib_rdata = '0;

  int checks = 0;
  int errs   = 0;
  int lat    = 2;
  bit stray  = 0;
  int cnt    = 0;
  bit started = 0;

  // reference model state
  logic [31:0] m_cmd, m_addr, m_wd, m_rd, m_rdata;
  bit          m_busy, m_rvalid;

  always #5 clk = ~clk;

  ind_bridge u_ind_bridge (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ib_req(ib_req), .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
    .ib_ready(ib_ready), .ib_rdata(ib_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [HW-1:0] a);
    case (a)
      12'h400: return m_cmd;
      12'h404: return m_addr;
      12'h408: return m_rd;
      12'h40C: return m_wd;
      default: return 32'h0;
    endcase
  endfunction

  // behavioural reference
  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_cmd = 0; m_addr = 0; m_wd = 0; m_rd = 0; m_rdata = 0;
      m_busy = 0; m_rvalid = 0;
    end else begin
      bit          ob;
      logic [31:0] oc;
      ob = m_busy;
      oc = m_cmd;
      m_rvalid = host_rd;
      if (host_rd) m_rdata = model_read(host_addr);
      if (ob && ib_ready) begin
        m_busy = 0;
        m_cmd  = oc | 32'h4;
        if (oc[0]) m_rd = ib_rdata;
      end
      if (host_wr) begin
        if (host_addr == 12'h404 && !ob) m_addr = host_wdata & AMASK;
        if (host_addr == 12'h40C && !ob) m_wd = host_wdata;
        if (host_addr == 12'h400) begin
          if (oc == 0 && (host_wdata[1:0] == 2'b01 || host_wdata[1:0] == 2'b10)) begin
            m_cmd  = {30'h0, host_wdata[1:0]};
            m_busy = 1;
          end else if (oc[2] && host_wdata == 0) begin
            m_cmd = 0;
          end
        end
      end
    end
  end

  // every-cycle comparison
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R5 ib_req", {31'h0, ib_req}, {31'h0, m_busy});
      chk("R2 host_rvalid", {31'h0, host_rvalid}, {31'h0, m_rvalid});
      if (m_rvalid) chk("R2 host_rdata", host_rdata, m_rdata);
      if (m_busy) begin
        chk("R3 ib_we", {31'h0, ib_we}, {31'h0, m_cmd[1]});
        chk("R8 ib_addr", {8'h0, ib_addr}, m_addr);
        chk("R8 ib_wdata", ib_wdata, m_wd);
      end
    end
  end

  // internal-bus responder
  always @(negedge clk) begin
    if (ib_req) begin
      if (cnt == 0) ib_ready = 1'b1;
      else begin ib_ready = 1'b0; cnt--; end
    end else begin
      ib_ready = stray;
      cnt = lat;
    end
  end

  task automatic hwrite(input logic [HW-1:0] a, input logic [31:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [HW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic expect_rd(input string tag, input logic [HW-1:0] a, input logic [31:0] e);
    logic [31:0] v;
    hread(a, v);
    chk(tag, v, e);
  endtask

  task automatic wait_ack(input string tag);
    logic [31:0] v;
    v = 0;
    for (int i = 0; i < 40 && !v[2]; i++) hread(12'h400, v);
    chk(tag, {31'h0, v[2]}, 32'h1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    errs++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values
    expect_rd("R1 cmd", 12'h400, 0);
    expect_rd("R1 addr", 12'h404, 0);
    expect_rd("R1 rdat", 12'h408, 0);
    expect_rd("R1 wdat", 12'h40C, 0);
    chk("R1 ib_req", {31'h0, ib_req}, 0);

    // R2 load and read back, unused and outside offsets
    hwrite(12'h40C, 32'hCAFE_F00D);
    hwrite(12'h404, 32'hAB12_3456);
    expect_rd("R2 wdat", 12'h40C, 32'hCAFE_F00D);
    expect_rd("R2 addr", 12'h404, 32'h0012_3456);
    hwrite(12'h410, 32'h1111_1111);
    expect_rd("R2 unused", 12'h410, 0);
    expect_rd("R2 outside", 12'h3FC, 0);

    // R3 internal write, with R8 dropped writes while busy
    lat = 8;
    hwrite(12'h400, 32'h2);
    chk("R3 req", {31'h0, ib_req}, 1);
    chk("R3 we", {31'h0, ib_we}, 1);
    chk("R3 addr", {8'h0, ib_addr}, 32'h0012_3456);
    chk("R3 wdata", ib_wdata, 32'hCAFE_F00D);
    hwrite(12'h404, 32'h0000_9999);
    hwrite(12'h40C, 32'h7777_7777);
    chk("R8 addr held", {8'h0, ib_addr}, 32'h0012_3456);
    wait_ack("R5 write ack");
    expect_rd("R5 cmd write done", 12'h400, 32'h6);
    expect_rd("R8 addr readback", 12'h404, 32'h0012_3456);
    expect_rd("R8 wdat readback", 12'h40C, 32'hCAFE_F00D);
    // R9 non-zero command while acknowledged
    hwrite(12'h400, 32'h1);
    expect_rd("R9 cmd unchanged", 12'h400, 32'h6);
    chk("R9 no req", {31'h0, ib_req}, 0);
    // R6 clear
    hwrite(12'h400, 32'h0);
    expect_rd("R6 cmd cleared", 12'h400, 0);

    // R4 internal read
    lat = 3;
    ib_rdata = 32'h1357_9BDF;
    hwrite(12'h404, 32'h0000_0055);
    hwrite(12'h400, 32'h1);
    chk("R4 we low", {31'h0, ib_we}, 0);
    hwrite(12'h400, 32'h2);
    wait_ack("R5 read ack");
    expect_rd("R5 cmd read done", 12'h400, 32'h5);
    expect_rd("R4 rdat", 12'h408, 32'h1357_9BDF);
    hwrite(12'h400, 32'h0);
    expect_rd("R6 cleared again", 12'h400, 0);

    // R7 both bits set
    hwrite(12'h400, 32'h3);
    chk("R7 no req", {31'h0, ib_req}, 0);
    expect_rd("R7 cmd zero", 12'h400, 0);

    // R10 stray ready while idle
    stray = 1;
    repeat (4) @(negedge clk);
    stray = 0;
    @(negedge clk);
    expect_rd("R10 cmd zero", 12'h400, 0);
    expect_rd("R10 rdat kept", 12'h408, 32'h1357_9BDF);

    // zero-latency read
    lat = 0;
    ib_rdata = 32'h0BAD_CAFE;
    hwrite(12'h400, 32'h1);
    wait_ack("R5 fast ack");
    expect_rd("R4 fast rdat", 12'h408, 32'h0BAD_CAFE);
    hwrite(12'h400, 32'h0);
    expect_rd("R6 final clear", 12'h400, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule